// File: doc/BRIEF.md
# Flash Program Controller

This block sits on the system side of a byte-wide parallel NOR flash bus. It accepts program and erase requests over a valid/ready handshake, then drives the flash pins with the unlock and command write cycles that each operation needs. After the last write it polls the flash until the embedded algorithm finishes. A request carries an operation code, a target address, a data byte and a polling-mode select.

Two ways of detecting completion are supported. In data-poll mode the controller reads the target address until bit 7 matches the expected value on consecutive reads and the full byte is correct. In toggle mode it finishes as soon as bit 6 holds still between two back-to-back reads. Every strobe width is a count of system clocks, so the same RTL fits any clock rate. The number of status reads is bounded. A flash that never finishes produces a timeout pulse instead of a hang.

Top module: `flash_prog_ctrl`

## Requirements
- R1: A program request (op 0) issues exactly four writes: (0x05555,0xAA), (0x02AAA,0x55), (0x05555,0xA0), then (target address, request data). Unlock addresses have all upper address bits zero.
- R2: A chip-erase request (op 1) issues exactly six writes: (0x05555,0xAA), (0x02AAA,0x55), (0x05555,0x80), (0x05555,0xAA), (0x02AAA,0x55), (0x05555,0x10).
- R3: A sector-erase request (op 2 or op 3) issues the same first five writes as R2, then a sixth write of (target address, 0x30).
- R4: While write-enable is low, chip-enable is low, output-enable is high and the data drivers are enabled. Address and write data stay constant for the whole low phase.
- R5: Each write-enable low phase lasts exactly STROBE_LO_CYC clocks. Between two writes of one sequence, write-enable stays high for at least STROBE_HI_CYC clocks.
- R6: In data-poll mode (req_toggle = 0), the controller finishes after CONFIRM_READS (default 2) consecutive reads whose bit 7 equals the expected bit 7, and the last of those reads must equal the expected byte. For a program, the expected byte is the written data. For an erase, it is 0xFF.
- R7: In toggle mode (req_toggle = 1), the controller finishes on the first read whose bit 6 equals bit 6 of the read just before it within the same operation.
- R8: req_ready is high only while idle, and a request is taken when req_valid and req_ready are both high. done is a one-clock pulse, raised as the controller returns to idle.
- R9: If POLL_MAX status reads complete without meeting the R6/R7 condition, timeout_err pulses for one clock instead of done. The controller then returns to idle and accepts a new request.
- R10: During and right after reset, all three strobes are high, the data drivers are off, req_ready is high, and done and timeout_err are low.
- R11: Every status read holds chip-enable and output-enable low, write-enable high and the data drivers off, with the target address on the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_op | input | 2 | 0 program, 1 chip erase, 2 or 3 sector erase |
| req_addr | input | AW | Target byte address, sector address, or poll address |
| req_data | input | 8 | Byte to program |
| req_toggle | input | 1 | 1 selects toggle polling, 0 selects data polling |
| done | output | 1 | One-clock pulse on successful completion |
| timeout_err | output | 1 | One-clock pulse when the poll limit is reached |
| fl_addr | output | AW | Flash address bus |
| fl_dout | output | 8 | Write data to flash |
| fl_drive | output | 1 | Enables the data-bus drivers toward the flash |
| fl_din | input | 8 | Read data from flash |
| fl_ce_n | output | 1 | Chip enable, active low |
| fl_oe_n | output | 1 | Output enable, active low |
| fl_we_n | output | 1 | Write enable, active low |

## Verification
The bench models a flash that reports busy for a chosen number of reads. Each poll-status bit moves as the device would, and the first read after completion has correct bit 7 but corrupt low bits. A controller that trusted that single read would finish one read early, and the exact read count exposes this. Toggle tests use busy lengths of both parities, so the corrupted bit 6 either ends the poll early or delays it by one read; a wrong bit-6 comparison shifts that count. Sector-erase tests use both sector codes and a high target address, which catches a swapped last write or truncated upper address bits. A timeout test is followed by a normal program, which shows that a controller stuck outside idle, or one that stops at the wrong read count, is detected.

// File: rtl/flash_ctrl_pkg.sv
package flash_ctrl_pkg;

   typedef enum logic [1:0] {
      OP_PROGRAM      = 2'd0,
      OP_CHIP_ERASE   = 2'd1,
      OP_SECTOR_ERASE = 2'd2,
      OP_SECTOR_ALT   = 2'd3
   } flash_op_e;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_WRITE = 2'd1,
      ST_READ  = 2'd2
   } ctl_state_e;

   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_ACT  = 2'd1,
      PH_REC  = 2'd2
   } bus_phase_e;

   localparam logic [15:0] UNLOCK_HI  = 16'h5555;
   localparam logic [15:0] UNLOCK_LO  = 16'h2AAA;
   localparam logic [7:0]  KEY_FIRST  = 8'hAA;
   localparam logic [7:0]  KEY_SECOND = 8'h55;
   localparam logic [7:0]  CMD_PROG   = 8'hA0;
   localparam logic [7:0]  CMD_ERASE  = 8'h80;
   localparam logic [7:0]  CMD_CHIP   = 8'h10;
   localparam logic [7:0]  CMD_SECTOR = 8'h30;

endpackage

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
   import flash_ctrl_pkg::*;
#(
   parameter int AW = 18
) (
   input  logic [1:0]    op,
   input  logic [2:0]    step,
   input  logic [AW-1:0] tgt_addr,
   input  logic [7:0]    tgt_data,
   output logic [AW-1:0] wr_addr,
   output logic [7:0]    wr_data,
   output logic          last_step
);

   localparam logic [AW-1:0] ADDR_HI = AW'(UNLOCK_HI);
   localparam logic [AW-1:0] ADDR_LO = AW'(UNLOCK_LO);

   logic is_prog;
   logic is_chip;

   assign is_prog = (op == OP_PROGRAM);
   assign is_chip = (op == OP_CHIP_ERASE);

   always_comb begin
      wr_addr = ADDR_HI;
      wr_data = KEY_FIRST;
      case (step)
         3'd0: begin
            wr_addr = ADDR_HI;
            wr_data = KEY_FIRST;
         end
         3'd1, 3'd4: begin
            wr_addr = ADDR_LO;
            wr_data = KEY_SECOND;
         end
         3'd2: begin
            wr_addr = ADDR_HI;
            wr_data = is_prog ? CMD_PROG : CMD_ERASE;
         end
         3'd3: begin
            wr_addr = is_prog ? tgt_addr : ADDR_HI;
            wr_data = is_prog ? tgt_data : KEY_FIRST;
         end
         default: begin
            wr_addr = is_chip ? ADDR_HI : tgt_addr;
            wr_data = is_chip ? CMD_CHIP : CMD_SECTOR;
         end
      endcase
   end

   assign last_step = is_prog ? (step == 3'd3) : (step == 3'd5);

endmodule

// File: rtl/flash_strobe_timer.sv
module flash_strobe_timer
   import flash_ctrl_pkg::*;
#(
   parameter int WR_ACT_CYC = 20,
   parameter int WR_REC_CYC = 20,
   parameter int RD_ACT_CYC = 16,
   parameter int RD_REC_CYC = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic start_read,
   output logic active,
   output logic is_read,
   output logic sample,
   output logic fin
);

   localparam int MAX_WR = (WR_ACT_CYC > WR_REC_CYC) ? WR_ACT_CYC : WR_REC_CYC;
   localparam int MAX_RD = (RD_ACT_CYC > RD_REC_CYC) ? RD_ACT_CYC : RD_REC_CYC;
   localparam int MAX_C  = (MAX_WR > MAX_RD) ? MAX_WR : MAX_RD;
   localparam int CW     = $clog2(MAX_C + 1);

   bus_phase_e    ph;
   logic [CW-1:0] cnt;
   logic          rd_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph   <= PH_IDLE;
         cnt  <= '0;
         rd_q <= 1'b0;
      end else begin
         case (ph)
            PH_IDLE: begin
               if (start) begin
                  ph   <= PH_ACT;
                  rd_q <= start_read;
                  cnt  <= start_read ? CW'(RD_ACT_CYC - 1) : CW'(WR_ACT_CYC - 1);
               end
            end
            PH_ACT: begin
               if (cnt == '0) begin
                  ph  <= PH_REC;
                  cnt <= rd_q ? CW'(RD_REC_CYC - 1) : CW'(WR_REC_CYC - 1);
               end else begin
                  cnt <= cnt - 1'b1;
               end
            end
            PH_REC: begin
               if (cnt == '0) ph <= PH_IDLE;
               else           cnt <= cnt - 1'b1;
            end
            default: ph <= PH_IDLE;
         endcase
      end
   end

   assign active  = (ph == PH_ACT);
   assign is_read = rd_q;
   assign sample  = active && rd_q && (cnt == '0);
   assign fin     = (ph == PH_REC) && (cnt == '0);

   // a new bus cycle may only be launched once the previous one has fully recovered
   assert_no_restart_R5: assert property (@(posedge clk) disable iff (!rst_n)
      start |-> (ph == PH_IDLE));

   assert_fin_after_act_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(active) |-> (ph == PH_REC));

endmodule

// File: rtl/flash_poll_judge.sv
module flash_poll_judge #(
   parameter int CONFIRM_READS = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       clear,
   input  logic       sample,
   input  logic       toggle_mode,
   input  logic [7:0] exp_byte,
   input  logic [7:0] rd_byte,
   output logic       pass
);

   logic pass_q;
   logic prev6;
   logic have_prev;
   logic bit7_hit;
   logic full_hit;
   logic dp_finish;

   assign bit7_hit = (rd_byte[7] == exp_byte[7]);
   assign full_hit = (rd_byte == exp_byte);

   generate
      if (CONFIRM_READS <= 1) begin : g_single
         assign dp_finish = full_hit;
      end else begin : g_multi
         localparam int HW = $clog2(CONFIRM_READS + 1);
         logic [HW-1:0] hit_run;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                     hit_run <= '0;
            else if (clear)                 hit_run <= '0;
            else if (sample && !toggle_mode) begin
               if (!bit7_hit)               hit_run <= '0;
               else if (hit_run != HW'(CONFIRM_READS - 1))
                                            hit_run <= hit_run + 1'b1;
            end
         end
         assign dp_finish = bit7_hit && full_hit && (hit_run == HW'(CONFIRM_READS - 1));
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pass_q    <= 1'b0;
         prev6     <= 1'b0;
         have_prev <= 1'b0;
      end else if (clear) begin
         pass_q    <= 1'b0;
         prev6     <= 1'b0;
         have_prev <= 1'b0;
      end else if (sample) begin
         if (toggle_mode) begin
            if (have_prev && (rd_byte[6] == prev6)) pass_q <= 1'b1;
            prev6     <= rd_byte[6];
            have_prev <= 1'b1;
         end else if (dp_finish) begin
            pass_q <= 1'b1;
         end
      end
   end

   assign pass = pass_q;

   // success may only appear on the edge that captured a status read (R6, R7)
   assert_pass_after_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pass_q) |-> $past(sample));

   assert_pass_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (pass_q && !clear) |=> pass_q);

endmodule

// File: rtl/flash_prog_ctrl.sv
module flash_prog_ctrl
   import flash_ctrl_pkg::*;
#(
   parameter int AW            = 18,
   parameter int CLK_NS        = 5,
   parameter int MIN_STROBE_NS = 100,
   parameter int STROBE_LO_CYC = 20,
   parameter int STROBE_HI_CYC = 20,
   parameter int READ_ACT_CYC  = 16,
   parameter int READ_REC_CYC  = 4,
   parameter int POLL_MAX      = 32,
   parameter int CONFIRM_READS = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_valid,
   output logic          req_ready,
   input  logic [1:0]    req_op,
   input  logic [AW-1:0] req_addr,
   input  logic [7:0]    req_data,
   input  logic          req_toggle,
   output logic          done,
   output logic          timeout_err,
   output logic [AW-1:0] fl_addr,
   output logic [7:0]    fl_dout,
   output logic          fl_drive,
   input  logic [7:0]    fl_din,
   output logic          fl_ce_n,
   output logic          fl_oe_n,
   output logic          fl_we_n
);

   localparam int PW = $clog2(POLL_MAX + 1);

   generate
      if (AW < 16) begin : g_bad_aw
         $error("AW must cover the 16-bit unlock addresses");
      end
      if (STROBE_LO_CYC * CLK_NS < MIN_STROBE_NS) begin : g_bad_lo
         $error("STROBE_LO_CYC too short for the minimum strobe width");
      end
      if (STROBE_HI_CYC * CLK_NS < MIN_STROBE_NS) begin : g_bad_hi
         $error("STROBE_HI_CYC too short for the minimum strobe width");
      end
      if (READ_ACT_CYC < 1 || READ_REC_CYC < 1) begin : g_bad_rd
         $error("read phases need at least one cycle each");
      end
      if (POLL_MAX < CONFIRM_READS || POLL_MAX < 2) begin : g_bad_poll
         $error("POLL_MAX must allow the confirming reads");
      end
   endgenerate

   ctl_state_e    state;
   logic [1:0]    op_q;
   logic [AW-1:0] addr_q;
   logic [7:0]    data_q;
   logic          tgl_q;
   logic [2:0]    step_q;
   logic          go_q;
   logic [PW-1:0] polls_q;
   logic          done_q;
   logic          tmo_q;

   logic [AW-1:0] seq_addr;
   logic [7:0]    seq_data;
   logic          seq_last;
   logic          t_act;
   logic          t_rd;
   logic          t_sample;
   logic          t_fin;
   logic          poll_pass;
   logic          accept;
   logic [7:0]    exp_byte;

   assign req_ready = (state == ST_IDLE);
   assign accept    = req_ready && req_valid;
   assign exp_byte  = (op_q == OP_PROGRAM) ? data_q : 8'hFF;

   flash_cmd_seq #(.AW(AW)) u_seq (
      .op        (op_q),
      .step      (step_q),
      .tgt_addr  (addr_q),
      .tgt_data  (data_q),
      .wr_addr   (seq_addr),
      .wr_data   (seq_data),
      .last_step (seq_last)
   );

   flash_strobe_timer #(
      .WR_ACT_CYC (STROBE_LO_CYC),
      .WR_REC_CYC (STROBE_HI_CYC),
      .RD_ACT_CYC (READ_ACT_CYC),
      .RD_REC_CYC (READ_REC_CYC)
   ) u_timer (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (go_q),
      .start_read (state == ST_READ),
      .active     (t_act),
      .is_read    (t_rd),
      .sample     (t_sample),
      .fin        (t_fin)
   );

   flash_poll_judge #(.CONFIRM_READS(CONFIRM_READS)) u_judge (
      .clk         (clk),
      .rst_n       (rst_n),
      .clear       (accept),
      .sample      (t_sample),
      .toggle_mode (tgl_q),
      .exp_byte    (exp_byte),
      .rd_byte     (fl_din),
      .pass        (poll_pass)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         op_q    <= 2'd0;
         addr_q  <= '0;
         data_q  <= 8'h00;
         tgl_q   <= 1'b0;
         step_q  <= 3'd0;
         go_q    <= 1'b0;
         polls_q <= '0;
         done_q  <= 1'b0;
         tmo_q   <= 1'b0;
      end else begin
         go_q   <= 1'b0;
         done_q <= 1'b0;
         tmo_q  <= 1'b0;
         case (state)
            ST_IDLE: begin
               if (req_valid) begin
                  op_q    <= req_op;
                  addr_q  <= req_addr;
                  data_q  <= req_data;
                  tgl_q   <= req_toggle;
                  step_q  <= 3'd0;
                  polls_q <= '0;
                  go_q    <= 1'b1;
                  state   <= ST_WRITE;
               end
            end
            ST_WRITE: begin
               if (t_fin) begin
                  go_q <= 1'b1;
                  if (seq_last) state  <= ST_READ;
                  else          step_q <= step_q + 3'd1;
               end
            end
            ST_READ: begin
               if (t_sample) polls_q <= polls_q + 1'b1;
               if (t_fin) begin
                  if (poll_pass) begin
                     done_q <= 1'b1;
                     state  <= ST_IDLE;
                  end else if (polls_q == PW'(POLL_MAX)) begin
                     tmo_q <= 1'b1;
                     state <= ST_IDLE;
                  end else begin
                     go_q <= 1'b1;
                  end
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign done        = done_q;
   assign timeout_err = tmo_q;
   assign fl_addr     = (state == ST_WRITE) ? seq_addr : addr_q;
   assign fl_dout     = seq_data;
   assign fl_drive    = (state == ST_WRITE);
   assign fl_ce_n     = !t_act;
   assign fl_we_n     = !(t_act && !t_rd);
   assign fl_oe_n     = !(t_act && t_rd);

   assert_write_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !fl_we_n |-> (!fl_ce_n && fl_oe_n && fl_drive));

   assert_write_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!fl_we_n && $past(!fl_we_n)) |-> ($stable(fl_addr) && $stable(fl_dout)));

   assert_read_strobe_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !fl_oe_n |-> (!fl_ce_n && fl_we_n && !fl_drive));

   assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (req_ready && !timeout_err));

   assert_flag_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (done || timeout_err) |=> (!done && !timeout_err));

   generate
      if (STROBE_LO_CYC >= 2) begin : g_lo_chk
         assert_we_min_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(fl_we_n) |=> !fl_we_n);
      end
   endgenerate

endmodule

// File: tb/tb_flash_prog_ctrl.sv
`timescale 1ns/1ps
module tb_flash_prog_ctrl;

   localparam int AW   = 18;
   localparam int LO   = 20;
   localparam int HI   = 20;
   localparam int RA   = 16;
   localparam int RR   = 4;
   localparam int PMAX = 32;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          req_valid;
   logic          req_ready;
   logic [1:0]    req_op;
   logic [AW-1:0] req_addr;
   logic [7:0]    req_data;
   logic          req_toggle;
   logic          done;
   logic          timeout_err;
   logic [AW-1:0] fl_addr;
   logic [7:0]    fl_dout;
   logic          fl_drive;
   logic [7:0]    fl_din;
   logic          fl_ce_n;
   logic          fl_oe_n;
   logic          fl_we_n;

   always #2.5 clk = ~clk;

   flash_prog_ctrl #(
      .AW(AW), .STROBE_LO_CYC(LO), .STROBE_HI_CYC(HI),
      .READ_ACT_CYC(RA), .READ_REC_CYC(RR), .POLL_MAX(PMAX)
   ) dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_op(req_op), .req_addr(req_addr), .req_data(req_data),
      .req_toggle(req_toggle), .done(done), .timeout_err(timeout_err),
      .fl_addr(fl_addr), .fl_dout(fl_dout), .fl_drive(fl_drive), .fl_din(fl_din),
      .fl_ce_n(fl_ce_n), .fl_oe_n(fl_oe_n), .fl_we_n(fl_we_n)
   );

   int checks = 0;
   int fails  = 0;
   bit finished = 0;

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // behavioural flash model
   logic [AW-1:0] exp_a_q[$];
   logic [7:0]    exp_d_q[$];
   string         cur_tag = "R1";
   int            busy_cfg  = 0;
   int            busy_left = 0;
   bit            garb = 0;
   bit            tog  = 0;
   logic [7:0]    true_byte = 8'hFF;
   logic          exp7 = 1'b1;
   logic [AW-1:0] poll_addr = '0;
   int            read_cnt = 0;
   int            lo_run = 0;
   int            hi_run = 0;
   bit            hi_valid = 0;
   bit            prev_we = 1;
   bit            prev_oe = 1;
   logic [AW-1:0] cap_a;
   logic [7:0]    cap_d;

   always_comb begin
      if (busy_left > 0)  fl_din = {~exp7, tog, 6'b0};
      else if (garb)      fl_din = {true_byte[7], ~true_byte[6:0]};
      else                fl_din = true_byte;
   end

   // per-clock comparison of the bus against the protocol model
   always @(negedge clk) begin
      if (rst_n) begin
         if (!fl_we_n) begin
            chk(!fl_ce_n && fl_oe_n && fl_drive, "R4", "write strobe levels",
                {fl_ce_n, fl_oe_n, fl_drive}, 3'b011);
            if (lo_run > 0)
               chk(fl_addr == cap_a && fl_dout == cap_d, "R4", "address/data held",
                   {fl_addr, fl_dout}, {cap_a, cap_d});
            if (prev_we && hi_valid)
               chk(hi_run >= HI, "R5", "write-enable high gap", hi_run, HI);
            cap_a = fl_addr;
            cap_d = fl_dout;
            lo_run++;
         end else if (!prev_we) begin
            chk(lo_run == LO, "R5", "write-enable low width", lo_run, LO);
            if (exp_a_q.size() == 0) begin
               chk(0, cur_tag, "unexpected write", {cap_a, cap_d}, 0);
            end else begin
               logic [AW-1:0] ea;
               logic [7:0]    ed;
               ea = exp_a_q.pop_front();
               ed = exp_d_q.pop_front();
               chk(cap_a == ea, cur_tag, "write address", cap_a, ea);
               chk(cap_d == ed, cur_tag, "write data", cap_d, ed);
               if (exp_a_q.size() == 0) begin
                  busy_left = busy_cfg;
                  garb      = 1;
                  tog       = 0;
                  read_cnt  = 0;
               end
            end
            lo_run   = 0;
            hi_run   = 1;
            hi_valid = 1;
         end else begin
            hi_run++;
         end
         if (!fl_oe_n) begin
            chk(!fl_ce_n && fl_we_n && !fl_drive && fl_addr == poll_addr, "R11",
                "read strobe levels and address", fl_addr, poll_addr);
         end else if (!prev_oe) begin
            read_cnt++;
            hi_valid = 0;
            if (busy_left > 0) begin
               busy_left--;
               tog = ~tog;
            end else begin
               garb = 0;
            end
         end
         prev_we = fl_we_n;
         prev_oe = fl_oe_n;
      end
   end

   function automatic int tgl_reads(input int busy, input logic [7:0] tv);
      logic pv, cv;
      pv = 1'b0;
      for (int i = 0; i < busy + 3; i++) begin
         if (i < busy)       cv = (i % 2) != 0;
         else if (i == busy) cv = ~tv[6];
         else                cv = tv[6];
         if (i > 0 && cv == pv) return i + 1;
         pv = cv;
      end
      return busy + 3;
   endfunction

   task automatic push(input logic [AW-1:0] a, input logic [7:0] d);
      exp_a_q.push_back(a);
      exp_d_q.push_back(d);
   endtask

   task automatic run_op(input logic [1:0] op, input logic [AW-1:0] a,
                         input logic [7:0] d, input bit tgl, input int busy,
                         input string tag, input bit hold_valid);
      int exp_reads;
      bit exp_to;
      int n;
      exp_a_q.delete();
      exp_d_q.delete();
      push(18'h05555, 8'hAA);
      push(18'h02AAA, 8'h55);
      if (op == 2'd0) begin
         push(18'h05555, 8'hA0);
         push(a, d);
         true_byte = d;
         exp7      = d[7];
      end else begin
         push(18'h05555, 8'h80);
         push(18'h05555, 8'hAA);
         push(18'h02AAA, 8'h55);
         if (op == 2'd1) push(18'h05555, 8'h10);
         else            push(a, 8'h30);
         true_byte = 8'hFF;
         exp7      = 1'b1;
      end
      cur_tag   = tag;
      busy_cfg  = busy;
      busy_left = 0;
      garb      = 0;
      read_cnt  = 0;
      poll_addr = a;
      exp_reads = tgl ? tgl_reads(busy, true_byte) : busy + 2;
      exp_to    = exp_reads > PMAX;

      @(negedge clk);
      chk(req_ready, "R8", "ready while idle", req_ready, 1);
      req_valid  = 1'b1;
      req_op     = op;
      req_addr   = a;
      req_data   = d;
      req_toggle = tgl;
      @(negedge clk);
      chk(!req_ready, "R8", "ready drops after accept", req_ready, 0);
      if (!hold_valid) req_valid = 1'b0;
      n = 0;
      while (!(done || timeout_err) && n < 20000) begin
         @(negedge clk);
         n++;
         if (hold_valid && n < 100)
            chk(!req_ready, "R8", "ready low while busy", req_ready, 0);
         if (n == 100) req_valid = 1'b0;
      end
      chk(n < 20000, tag, "operation finished", n, 0);
      if (exp_to) begin
         chk(timeout_err && !done, "R9", "timeout flag", {done, timeout_err}, 2'b01);
         chk(read_cnt == PMAX, "R9", "reads before timeout", read_cnt, PMAX);
      end else begin
         chk(done && !timeout_err, tgl ? "R7" : "R6", "done flag",
             {done, timeout_err}, 2'b10);
         chk(read_cnt == exp_reads, tgl ? "R7" : "R6", "status read count",
             read_cnt, exp_reads);
      end
      chk(exp_a_q.size() == 0, tag, "all writes issued", exp_a_q.size(), 0);
      @(negedge clk);
      chk(!done && !timeout_err, "R8", "flag is one-clock pulse",
          {done, timeout_err}, 0);
      chk(req_ready, "R8", "ready after finish", req_ready, 1);
   endtask

   initial begin
      rst_n      = 1'b0;
      req_valid  = 1'b0;
      req_op     = 2'd0;
      req_addr   = '0;
      req_data   = 8'h00;
      req_toggle = 1'b0;
      repeat (4) @(negedge clk);
      chk(fl_ce_n && fl_oe_n && fl_we_n && !fl_drive, "R10", "strobes in reset",
          {fl_ce_n, fl_oe_n, fl_we_n, fl_drive}, 4'b1110);
      chk(req_ready && !done && !timeout_err, "R10", "handshake in reset",
          {req_ready, done, timeout_err}, 3'b100);
      rst_n = 1'b1;
      @(negedge clk);
      chk(fl_ce_n && fl_oe_n && fl_we_n && req_ready, "R10", "state after reset",
          {fl_ce_n, fl_oe_n, fl_we_n, req_ready}, 4'b1111);

      run_op(2'd0, 18'h12345, 8'h5A, 1'b0, 3,    "R1", 1'b0);
      run_op(2'd0, 18'h3FFFF, 8'hC3, 1'b1, 4,    "R1", 1'b1);
      run_op(2'd1, 18'h00000, 8'h00, 1'b0, 2,    "R2", 1'b0);
      run_op(2'd2, 18'h23456, 8'h00, 1'b1, 5,    "R3", 1'b0);
      run_op(2'd3, 18'h3A001, 8'h00, 1'b0, 0,    "R3", 1'b0);
      run_op(2'd0, 18'h00010, 8'h80, 1'b0, 1000, "R9", 1'b0);
      run_op(2'd0, 18'h00011, 8'h80, 1'b1, 0,    "R9", 1'b0);
      run_op(2'd1, 18'h00000, 8'h00, 1'b1, 1000, "R2", 1'b0);
      run_op(2'd0, 18'h1ABCD, 8'h7F, 1'b1, 3,    "R1", 1'b0);

      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      #(5.0 * 200000);
      if (!finished) begin
         fails++;
         checks++;
         $display("FAIL watchdog: actual=expired expected=finished");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

endmodule